// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block collects a large number of level-sensitive interrupt inputs and sorts them into groups of eight. Each group drives one output line. That line is high whenever at least one source in the group is both asserted and enabled. A downstream interrupt controller therefore sees one line per group instead of every individual source.

Software uses a word-addressed register port to manage the enables. Enables are only ever raised through a set word or lowered through a clear word, so a read-modify-write sequence is never needed. The same port reads the raw source levels, the levels after masking, and a summary with one bit per group that is currently asserting.

The registers are laid out in quads of four 32-bit words. One quad serves four groups, and each group owns one byte lane of every word in its quad. An optional external mode makes every group at or above a configured limit ignore its inputs.

Top module: `irq_group_merger`

## Requirements
- R1: Input index n feeds group n>>3, at bit n&7 of that group's 8-bit source vector.
- R2: A source's pending bit follows its input level with no latching. A change on an input is visible in the raw status one clock edge after it is sampled.
- R3: Output grp_irq[g] is high exactly when (enable mask AND pending vector) of group g is nonzero. It reflects an input change or an enable write from the first clock edge after that change or write.
- R4: Word address 4q+w belongs to quad q, which serves groups 4q to 4q+3. Byte lane k (bits 8k+7:8k) of every word in the quad belongs to group 4q+k.
- R5: A write to word 0 of a quad ORs each byte into its group's enable mask. A write to word 1 clears the enable bits wherever the written byte holds ones.
- R6: A read of word 2 of a quad returns the four raw pending vectors. A read of word 3 returns the four masked vectors (mask AND pending). Both use the lane packing of R4.
- R7: The two words just past the last quad are the summary words, at word addresses 64 and 65 with the default 64 groups. Bit b of summary word s equals grp_irq[32s+b].
- R8: A read of word 0 or word 1 of a quad returns the last data written to that exact address, not the current mask.
- R9: Reset clears all masks, all pending vectors and all word-0 and word-1 write copies. The exception is word addresses 48, 49, 52 and 53, whose copies reset to 0x01010101.
- R10: When external mode is on, every source in a group at or above the external group limit is ignored. Its pending bits stay zero and its output stays low.
- R11: A write to a status word, to a summary word or outside the window changes nothing, and bus_err is high for the one cycle after that write. A read outside the window returns zero.
- R12: bus_rdata takes its new value at the clock edge that accepts a read. It holds that value while no read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | N_GRP*8 | Level-sensitive interrupt sources |
| bus_valid | input | 1 | Access request, one access per cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle flag for a rejected write |
| grp_irq | output | N_GRP | One combined interrupt line per group |

## Verification
The bench builds the block with the default 64 groups and a 7-bit word address. External mode is turned on with a limit of 60, so the four highest groups exercise the ignore path while the preset copies at quads 12 and 13 remain present. The bench sweeps all 512 inputs one at a time. It does this once with every enable clear and once with every enable set, and checks each input's group, byte lane, bit, output line and summary bit against arithmetic on the index. It then exercises partial set and clear patterns, rejected writes and out-of-window reads against a model of the masks and write copies kept in the bench.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_PER_GRP = 8;
    localparam int GRP_PER_QUAD = 4;
    localparam int WORDS_PER_QUAD = 4;

    typedef logic [SRC_PER_GRP-1:0] src_vec_t;

    typedef enum logic [1:0] {
        WK_SET = 2'd0,
        WK_CLR = 2'd1,
        WK_RAW = 2'd2,
        WK_MSK = 2'd3
    } word_kind_e;
endpackage

// File: rtl/irqc_group.sv
module irqc_group
    import irqc_pkg::*;
#(
    parameter int GIDX      = 0,
    parameter bit EXT_EN    = 1'b0,
    parameter int EXT_LIMIT = 64
) (
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t src_in,
    input  logic     set_en,
    input  logic     clr_en,
    input  src_vec_t bits,
    output src_vec_t pend,
    output src_vec_t mask,
    output logic     irq_out
);
    localparam bit IGNORED = EXT_EN && (GIDX >= EXT_LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mask <= '0;
        else if (set_en) mask <= mask | bits;
        else if (clr_en) mask <= mask & ~bits;
    end

    generate
        if (IGNORED) begin : g_ignored
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pend <= '0;
                else        pend <= pend;
            end
            // R10: input activity never reaches the pending vector
            p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(src_in) |=> pend == '0);
        end else begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pend <= '0;
                else        pend <= src_in;
            end
            p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> pend == $past(src_in));
        end
    endgenerate

    assign irq_out = |(mask & pend);

    p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (mask & $past(bits)) == $past(bits));
    p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !set_en) |=> (mask & $past(bits)) == '0);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en && !clr_en) |=> $stable(mask));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int          N_GRP      = 64,
    parameter int          ADDR_W     = 7,
    parameter int          PRESET_QA  = 12,
    parameter int          PRESET_QB  = 13,
    parameter logic [31:0] PRESET_VAL = 32'h0101_0101,
    localparam int NQ    = N_GRP / GRP_PER_QUAD,
    localparam int NS    = (N_GRP + 31) / 32,
    localparam int QEND  = NQ * WORDS_PER_QUAD,
    localparam int WIN   = QEND + NS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_valid,
    input  logic                         bus_write,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    input  logic [N_GRP*SRC_PER_GRP-1:0] pend_flat,
    input  logic [N_GRP*SRC_PER_GRP-1:0] mask_flat,
    input  logic [N_GRP-1:0]             grp_irq,
    output logic [NQ-1:0]                set_stb,
    output logic [NQ-1:0]                clr_stb,
    output logic [31:0]                  bus_rdata,
    output logic                         bus_err
);
    logic       wr, rd, in_quads, in_win, bad_wr;
    logic [ADDR_W-3:0] qidx;
    word_kind_e wk;
    logic [31:0] shadow [NQ][2];
    logic [31:0] rd_val;
    logic [NS*32-1:0] sum_pad;
    int qbase, sidx;

    function automatic logic [31:0] shadow_init(int q);
        return (q == PRESET_QA || q == PRESET_QB) ? PRESET_VAL : 32'h0;
    endfunction

    assign wr       = bus_valid && bus_write;
    assign rd       = bus_valid && !bus_write;
    assign in_quads = bus_addr < ADDR_W'(QEND);
    assign in_win   = bus_addr < ADDR_W'(WIN);
    assign qidx     = bus_addr[ADDR_W-1:2];
    assign wk       = word_kind_e'(bus_addr[1:0]);
    assign bad_wr   = wr && !(in_quads && (wk == WK_SET || wk == WK_CLR));
    assign qbase    = int'(qidx) * GRP_PER_QUAD;
    assign sidx     = int'(bus_addr) - QEND;

    generate
        for (genvar q = 0; q < NQ; q++) begin : g_quad
            logic hit;
            assign hit        = wr && in_quads && (qidx == (ADDR_W-2)'(q));
            assign set_stb[q] = hit && (wk == WK_SET);
            assign clr_stb[q] = hit && (wk == WK_CLR);

            for (genvar w = 0; w < 2; w++) begin : g_word
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n)
                        shadow[q][w] <= shadow_init(q);
                    else if (hit && bus_addr[1:0] == 2'(w))
                        shadow[q][w] <= bus_wdata;
                end
            end
        end
    endgenerate

    always_comb begin
        sum_pad = '0;
        sum_pad[N_GRP-1:0] = grp_irq;
    end

    always_comb begin
        rd_val = '0;
        if (in_quads) begin
            unique case (wk)
                WK_SET: rd_val = shadow[qidx][0];
                WK_CLR: rd_val = shadow[qidx][1];
                WK_RAW: for (int k = 0; k < GRP_PER_QUAD; k++)
                            rd_val[k*8 +: 8] = pend_flat[(qbase + k)*8 +: 8];
                WK_MSK: for (int k = 0; k < GRP_PER_QUAD; k++)
                            rd_val[k*8 +: 8] = pend_flat[(qbase + k)*8 +: 8]
                                             & mask_flat[(qbase + k)*8 +: 8];
            endcase
        end else if (in_win) begin
            rd_val = sum_pad[sidx*32 +: 32];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= bad_wr;
            if (rd) bus_rdata <= rd_val;
        end
    end

    p_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !in_win) |=> bus_err);
    p_noerr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> !bus_err);
    p_rd_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !in_win) |=> bus_rdata == '0);
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
    p_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({set_stb, clr_stb}) <= 1);
endmodule

// File: rtl/irq_group_merger.sv
module irq_group_merger
    import irqc_pkg::*;
#(
    parameter int N_GRP     = 64,
    parameter int ADDR_W    = 7,
    parameter bit EXT_EN    = 1'b0,
    parameter int EXT_LIMIT = 64,
    localparam int N_SRC    = N_GRP * SRC_PER_GRP,
    localparam int NQ       = N_GRP / GRP_PER_QUAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [N_GRP-1:0]  grp_irq
);
    logic [N_SRC-1:0] pend_flat, mask_flat;
    logic [NQ-1:0]    set_stb, clr_stb;

    generate
        for (genvar g = 0; g < N_GRP; g++) begin : g_grp
            localparam int Q = g / GRP_PER_QUAD;
            localparam int K = g % GRP_PER_QUAD;
            irqc_group #(
                .GIDX(g), .EXT_EN(EXT_EN), .EXT_LIMIT(EXT_LIMIT)
            ) u_grp (
                .clk    (clk),
                .rst_n  (rst_n),
                .src_in (irq_in[g*8 +: 8]),
                .set_en (set_stb[Q]),
                .clr_en (clr_stb[Q]),
                .bits   (bus_wdata[K*8 +: 8]),
                .pend   (pend_flat[g*8 +: 8]),
                .mask   (mask_flat[g*8 +: 8]),
                .irq_out(grp_irq[g])
            );
        end
    endgenerate

    irqc_regs #(.N_GRP(N_GRP), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_valid(bus_valid),
        .bus_write(bus_write),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .pend_flat(pend_flat),
        .mask_flat(mask_flat),
        .grp_irq  (grp_irq),
        .set_stb  (set_stb),
        .clr_stb  (clr_stb),
        .bus_rdata(bus_rdata),
        .bus_err  (bus_err)
    );

    // R3: after a reset-free cycle with no enable change, a group with no
    // sampled source asserted must be low
    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_valid && irq_in == '0) |=> grp_irq == '0);
endmodule

// File: tb/irq_group_merger_tb_top.sv
module irq_group_merger_tb_top;
    localparam int NG = 64, AW = 7, LIM = 60;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NG*8-1:0] irq_in = '0;
    logic bus_valid = 0, bus_write = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic bus_err;
    logic [NG-1:0] grp_irq;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0]  exp_mask [NG];
    logic [31:0] exp_sh [64];

    always #2.5 clk = ~clk;

    irq_group_merger #(.N_GRP(NG), .ADDR_W(AW), .EXT_EN(1'b1), .EXT_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_valid(bus_valid),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .grp_irq(grp_irq));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pend_of(int g);
        return (g < LIM) ? irq_in[g*8 +: 8] : 8'h00;
    endfunction

    function automatic logic [NG-1:0] exp_grp();
        logic [NG-1:0] v;
        for (int g = 0; g < NG; g++) v[g] = |(pend_of(g) & exp_mask[g]);
        return v;
    endfunction

    function automatic logic [31:0] exp_word(int a);
        logic [31:0] v = '0;
        logic [NG-1:0] s = exp_grp();
        if (a < 64) begin
            for (int k = 0; k < 4; k++) begin
                int g = (a / 4) * 4 + k;
                if (a % 4 == 2) v[k*8 +: 8] = pend_of(g);
                if (a % 4 == 3) v[k*8 +: 8] = pend_of(g) & exp_mask[g];
            end
            if (a % 4 < 2) v = exp_sh[a];
        end else if (a < 66) begin
            v = s[(a-64)*32 +: 32];
        end
        return v;
    endfunction

    task automatic bus_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
        if (a < 64 && a % 4 < 2) begin
            exp_sh[a] = d;
            for (int k = 0; k < 4; k++) begin
                int g = (a / 4) * 4 + k;
                if (a % 4 == 0) exp_mask[g] = exp_mask[g] | d[k*8 +: 8];
                else            exp_mask[g] = exp_mask[g] & ~d[k*8 +: 8];
            end
        end
    endtask

    task automatic bus_rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = AW'(a);
        @(negedge clk);
        bus_valid = 0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input int a, input string tag);
        logic [31:0] d;
        bus_rd(a, d);
        chk(d === exp_word(a), tag, 64'(d), 64'(exp_word(a)));
    endtask

    task automatic sweep(input bit masked);
        for (int n = 0; n < NG*8; n++) begin
            int g = n >> 3;
            @(negedge clk);
            irq_in = '0; irq_in[n] = 1'b1;
            @(negedge clk);
            chk(grp_irq === exp_grp(), "R3 R10 output per input", 64'(grp_irq), 64'(exp_grp()));
            rd_chk((g >> 2) * 4 + 2, "R1 R2 R4 raw lane");
            if (masked) begin
                rd_chk((g >> 2) * 4 + 3, "R6 masked lane");
                rd_chk(64 + (g >> 5), "R7 summary bit");
            end
        end
        @(negedge clk); irq_in = '0;
    endtask

    initial begin
        logic [31:0] d, d2;
        for (int g = 0; g < NG; g++) exp_mask[g] = '0;
        for (int a = 0; a < 64; a++)
            exp_sh[a] = (a == 48 || a == 49 || a == 52 || a == 53) ? 32'h0101_0101 : 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(grp_irq === '0, "R9 reset outputs", 64'(grp_irq), 64'h0);
        for (int a = 0; a < 66; a++) rd_chk(a, "R9 reset register");

        sweep(1'b0);
        for (int q = 0; q < 16; q++) bus_wr(q*4, 32'hFFFF_FFFF);
        sweep(1'b1);

        rd_chk(0, "R8 set copy");
        bus_wr(1, 32'h0F0F_0F0F);
        rd_chk(1, "R8 clear copy");
        rd_chk(0, "R8 set copy kept");
        @(negedge clk); irq_in = '0; irq_in[31:0] = '1;
        @(negedge clk);
        rd_chk(3, "R5 R6 clear pattern");
        bus_wr(0, 32'h0000_0001);
        rd_chk(3, "R5 R6 set OR");
        bus_wr(1, 32'hFFFF_FFFF);
        chk(grp_irq[3:0] === 4'h0, "R3 R5 clear timing", 64'(grp_irq[3:0]), 64'h0);
        bus_wr(0, 32'h0080_0000);
        chk(grp_irq[3:0] === 4'h4, "R3 R5 set timing", 64'(grp_irq[3:0]), 64'h4);
        irq_in[511:480] = '1;
        @(negedge clk);
        chk(grp_irq[63:60] === 4'h0, "R10 ignored groups", 64'(grp_irq[63:60]), 64'h0);
        rd_chk(62, "R10 ignored raw");

        foreach (d2[i]) d2[i] = 1'b0;
        for (int i = 0; i < 5; i++) begin
            int a = (i == 0) ? 2 : (i == 1) ? 3 : (i == 2) ? 64 : (i == 3) ? 65 : 100;
            bus_wr(a, 32'hFFFF_FFFF);
            chk(bus_err === 1'b1, "R11 error flag", 64'(bus_err), 64'h1);
            @(negedge clk);
            chk(bus_err === 1'b0, "R11 error one cycle", 64'(bus_err), 64'h0);
        end
        chk(grp_irq === exp_grp(), "R11 outputs untouched", 64'(grp_irq), 64'(exp_grp()));
        rd_chk(3, "R11 masks untouched");
        rd_chk(0, "R11 copies untouched");
        rd_chk(100, "R11 out of window read");
        rd_chk(127, "R11 top address read");

        bus_rd(64, d);
        repeat (4) @(negedge clk);
        chk(bus_rdata === d, "R12 read data held", 64'(bus_rdata), 64'(d));
        chk(d === exp_word(64), "R12 read data value", 64'(d), 64'(exp_word(64)));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog R3 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule